// File: doc/BRIEF.md
# 32-bit Register/Memory Operand Address Decoder

This block parses the addressing bytes that follow an opcode when 32-bit addressing is in force. It takes the operand-descriptor byte (mod in bits 7:6, reg in bits 5:3, rm in bits 2:0), then an optional scale-index-base byte, then any displacement bytes, one byte per cycle on a valid-qualified byte stream. When the last needed byte has been taken, it reports the decoded operand shape in one registered result.

The result says whether the operand is a register or a memory reference. It gives the reg field, the direct register number for register operands, the base and index registers with their valid flags, the index multiplier, the displacement length and the total number of addressing bytes. The displacement bytes are counted and consumed but their value is not kept. The byte after a completed operand is always taken as the next descriptor byte. Address arithmetic, segment selection and 16-bit addressing forms are left to other blocks.

Top module: `a32_addr_decoder`

## Requirements
- R1: On every completed operand, `reg_field_o` equals bits 5:3 of the descriptor byte.
- R2: A descriptor with mod = 11 completes on that byte as a register operand. `is_reg_o` = 1 and `rm_reg_o` = bits 2:0. Both valid flags are 0, base and index are 0, `scale_mul_o` = 1, `disp_len_o` = 0 and `total_len_o` = 1.
- R3: A descriptor with mod = 00 and rm = 101 gives a memory operand with no base and no index, a LONG_DISP-byte displacement (4 by default) and a total of 1 + LONG_DISP.
- R4: A descriptor with mod other than 11 and rm = 100 makes the next byte a scale-index-base byte, and that byte counts in `total_len_o`.
- R5: In the scale-index-base byte, bits 7:6 are the scale s, bits 5:3 the index and bits 2:0 the base. `scale_mul_o` = 2^s (1, 2, 4 or 8) whether or not an index is used.
- R6: An index field of 100 gives `index_vld_o` = 0 and `index_reg_o` = 0. Any other value gives `index_vld_o` = 1 with that register number.
- R7: A base field of 101 with mod = 00 gives `base_vld_o` = 0, `base_reg_o` = 0 and a LONG_DISP-byte displacement.
- R8: A base field of 101 with mod = 01 or 10 gives base register 5, valid, and a displacement of SHORT_DISP or LONG_DISP bytes.
- R9: In all other memory forms, mod 00 adds no displacement, mod 01 adds SHORT_DISP bytes (1 by default) and mod 10 adds LONG_DISP bytes (4 by default). Without a scale-index-base byte the base is the rm register, the index is invalid and `scale_mul_o` = 1. `rm_reg_o` is 0 for every memory operand.
- R10: `total_len_o` = 1 + (1 if a scale-index-base byte is present) + `disp_len_o`. `done_o` is high for exactly the one cycle after the clock edge that consumed the final byte. All result outputs hold their values until the next `done_o`.
- R11: A cycle with `byte_valid_i` low consumes no byte and changes no decode progress.
- R12: While `rst_n` is low every output is 0 and bytes are ignored. After reset the first valid byte is taken as a descriptor byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid_i | input | 1 | A byte is presented this cycle and is consumed |
| byte_i | input | 8 | Addressing byte |
| done_o | output | 1 | One-cycle strobe: a new result is on the outputs |
| is_reg_o | output | 1 | Operand is a register, not memory |
| reg_field_o | output | 3 | reg field of the descriptor byte |
| rm_reg_o | output | 3 | Register number for a register operand, else 0 |
| base_vld_o | output | 1 | A base register takes part in the address |
| base_reg_o | output | 3 | Base register number, 0 when absent |
| index_vld_o | output | 1 | An index register takes part in the address |
| index_reg_o | output | 3 | Index register number, 0 when absent |
| scale_mul_o | output | 4 | Index multiplier 1, 2, 4 or 8 |
| disp_len_o | output | 4 | Displacement length in bytes |
| total_len_o | output | 4 | Descriptor + scale-index-base + displacement bytes |

## Verification
The bench builds the decoder with its default displacement lengths, 1 and 4 bytes. These values give every operand a length of 1, 2, 3, 5 or 6 bytes, so each escape form appears at its real size. With them, a full sweep of all 256 descriptor bytes, and of all 256 scale-index-base bytes under each of the three memory mod values, finishes in a few thousand cycles. Idle cycles are inserted inside and between operands, and register operands arrive back to back, so stalls and single-byte completions on consecutive cycles are both checked against the behavioural model.

// File: rtl/a32_pkg.sv
package a32_pkg;

  localparam int LEN_W = 4;

  localparam logic [1:0] MOD_DIRECT   = 2'b11;
  localparam logic [1:0] MOD_NO_DISP  = 2'b00;
  localparam logic [1:0] MOD_SHORT    = 2'b01;
  localparam logic [1:0] MOD_LONG     = 2'b10;
  localparam logic [2:0] RM_SIB_ESC   = 3'b100;
  localparam logic [2:0] RM_DISP_ESC  = 3'b101;
  localparam logic [2:0] IDX_NONE     = 3'b100;
  localparam logic [2:0] BASE_ESC     = 3'b101;

  typedef enum logic [1:0] {
    DK_NONE  = 2'd0,
    DK_SHORT = 2'd1,
    DK_LONG  = 2'd2
  } disp_kind_e;

  typedef enum logic [1:0] {
    ST_DESC = 2'd0,
    ST_SIB  = 2'd1,
    ST_DISP = 2'd2
  } dec_state_e;

  typedef struct packed {
    logic             is_reg;
    logic [2:0]       reg_f;
    logic [2:0]       rm_reg;
    logic             base_vld;
    logic [2:0]       base;
    logic             idx_vld;
    logic [2:0]       idx;
    logic [3:0]       scale_mul;
    logic [LEN_W-1:0] disp_len;
    logic [LEN_W-1:0] total_len;
  } operand_t;

  // Index multiplier from the two-bit scale code.
  function automatic logic [3:0] scale_to_mul(input logic [1:0] s);
    return 4'b0001 << s;
  endfunction

  // Displacement class from mod; esc_long selects the long form under mod 00.
  function automatic disp_kind_e mod_disp_kind(input logic [1:0] md,
                                               input logic       esc_long);
    disp_kind_e k;
    case (md)
      MOD_SHORT:   k = DK_SHORT;
      MOD_LONG:    k = DK_LONG;
      MOD_NO_DISP: k = esc_long ? DK_LONG : DK_NONE;
      default:     k = DK_NONE;
    endcase
    return k;
  endfunction

  // Byte count of a displacement class.
  function automatic logic [LEN_W-1:0] kind_len(input disp_kind_e k,
                                                input int short_n,
                                                input int long_n);
    logic [LEN_W-1:0] n;
    case (k)
      DK_SHORT: n = LEN_W'(short_n);
      DK_LONG:  n = LEN_W'(long_n);
      default:  n = '0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/a32_desc_split.sv
module a32_desc_split
  import a32_pkg::*;
(
  input  logic [7:0]  desc_i,
  output logic [1:0]  mod_o,
  output logic [2:0]  reg_o,
  output logic [2:0]  rm_o,
  output logic        direct_o,
  output logic        sib_next_o,
  output logic        disp_only_o,
  output disp_kind_e  kind_o
);

  assign mod_o       = desc_i[7:6];
  assign reg_o       = desc_i[5:3];
  assign rm_o        = desc_i[2:0];
  assign direct_o    = (mod_o == MOD_DIRECT);
  assign sib_next_o  = !direct_o && (rm_o == RM_SIB_ESC);
  assign disp_only_o = (mod_o == MOD_NO_DISP) && (rm_o == RM_DISP_ESC);
  assign kind_o      = mod_disp_kind(mod_o, disp_only_o);

endmodule

// File: rtl/a32_sib_split.sv
module a32_sib_split
  import a32_pkg::*;
(
  input  logic [7:0]  sib_i,
  input  logic [1:0]  mod_i,
  output logic [3:0]  scale_mul_o,
  output logic        idx_vld_o,
  output logic [2:0]  idx_o,
  output logic        base_vld_o,
  output logic [2:0]  base_o,
  output disp_kind_e  kind_o
);

  logic [2:0] raw_idx;
  logic [2:0] raw_base;
  logic       base_absent;

  assign raw_idx     = sib_i[5:3];
  assign raw_base    = sib_i[2:0];
  assign base_absent = (mod_i == MOD_NO_DISP) && (raw_base == BASE_ESC);

  assign scale_mul_o = scale_to_mul(sib_i[7:6]);
  assign idx_vld_o   = (raw_idx != IDX_NONE);
  assign idx_o       = idx_vld_o ? raw_idx : 3'd0;
  assign base_vld_o  = !base_absent;
  assign base_o      = base_absent ? 3'd0 : raw_base;
  assign kind_o      = mod_disp_kind(mod_i, base_absent);

endmodule

// File: rtl/a32_disp_counter.sv
module a32_disp_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          step_i,
  output logic          last_o
);

  logic [CW-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (load_i) begin
      rem_q <= load_val_i;
    end else if (step_i && rem_q != '0) begin
      rem_q <= rem_q - CW'(1);
    end
  end

  assign last_o = (rem_q == CW'(1));

endmodule

// File: rtl/a32_addr_decoder.sv
module a32_addr_decoder
  import a32_pkg::*;
#(
  parameter int SHORT_DISP = 1,
  parameter int LONG_DISP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  output logic             done_o,
  output logic             is_reg_o,
  output logic [2:0]       reg_field_o,
  output logic [2:0]       rm_reg_o,
  output logic             base_vld_o,
  output logic [2:0]       base_reg_o,
  output logic             index_vld_o,
  output logic [2:0]       index_reg_o,
  output logic [3:0]       scale_mul_o,
  output logic [LEN_W-1:0] disp_len_o,
  output logic [LEN_W-1:0] total_len_o
);

  localparam logic [LEN_W-1:0] ONE_BYTE = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO_BYTE = LEN_W'(2);

  // Decode progress
  dec_state_e state_q, state_d;
  logic [1:0] mod_q, mod_d;
  operand_t   pend_q, pend_d;
  operand_t   res_q, res_d;
  logic       done_q;

  // Named events, brought out for the checker
  logic ev_desc_take;
  logic ev_sib_take;
  logic ev_disp_take;
  logic ev_finish;

  // Descriptor byte decode
  logic [1:0] d_mod;
  logic [2:0] d_reg;
  logic [2:0] d_rm;
  logic       d_direct;
  logic       d_sib_next;
  logic       d_disp_only;
  disp_kind_e d_kind;

  a32_desc_split u_desc (
    .desc_i      (byte_i),
    .mod_o       (d_mod),
    .reg_o       (d_reg),
    .rm_o        (d_rm),
    .direct_o    (d_direct),
    .sib_next_o  (d_sib_next),
    .disp_only_o (d_disp_only),
    .kind_o      (d_kind)
  );

  // Scale-index-base byte decode, using the stored mod
  logic [3:0] s_mul;
  logic       s_idx_vld;
  logic [2:0] s_idx;
  logic       s_base_vld;
  logic [2:0] s_base;
  disp_kind_e s_kind;

  a32_sib_split u_sib (
    .sib_i       (byte_i),
    .mod_i       (mod_q),
    .scale_mul_o (s_mul),
    .idx_vld_o   (s_idx_vld),
    .idx_o       (s_idx),
    .base_vld_o  (s_base_vld),
    .base_o      (s_base),
    .kind_o      (s_kind)
  );

  // Displacement byte counter
  logic             cnt_load;
  logic [LEN_W-1:0] cnt_val;
  logic             cnt_last;

  a32_disp_counter #(.CW(LEN_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .step_i     (ev_disp_take),
    .last_o     (cnt_last)
  );

  // Candidate results
  operand_t cand_desc;
  operand_t cand_sib;

  always_comb begin
    cand_desc           = '0;
    cand_desc.is_reg    = d_direct;
    cand_desc.reg_f     = d_reg;
    cand_desc.rm_reg    = d_direct ? d_rm : 3'd0;
    cand_desc.base_vld  = !d_direct && !d_disp_only;
    cand_desc.base      = cand_desc.base_vld ? d_rm : 3'd0;
    cand_desc.idx_vld   = 1'b0;
    cand_desc.idx       = 3'd0;
    cand_desc.scale_mul = 4'd1;
    cand_desc.disp_len  = d_direct ? '0 : kind_len(d_kind, SHORT_DISP, LONG_DISP);
    cand_desc.total_len = ONE_BYTE + cand_desc.disp_len;
  end

  always_comb begin
    cand_sib           = '0;
    cand_sib.is_reg    = 1'b0;
    cand_sib.reg_f     = pend_q.reg_f;
    cand_sib.rm_reg    = 3'd0;
    cand_sib.base_vld  = s_base_vld;
    cand_sib.base      = s_base;
    cand_sib.idx_vld   = s_idx_vld;
    cand_sib.idx       = s_idx;
    cand_sib.scale_mul = s_mul;
    cand_sib.disp_len  = kind_len(s_kind, SHORT_DISP, LONG_DISP);
    cand_sib.total_len = TWO_BYTE + cand_sib.disp_len;
  end

  assign ev_desc_take = byte_valid_i && (state_q == ST_DESC);
  assign ev_sib_take  = byte_valid_i && (state_q == ST_SIB);
  assign ev_disp_take = byte_valid_i && (state_q == ST_DISP);

  // Sequencing
  always_comb begin
    state_d   = state_q;
    mod_d     = mod_q;
    pend_d    = pend_q;
    res_d     = res_q;
    ev_finish = 1'b0;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    unique case (state_q)
      ST_DESC: begin
        if (ev_desc_take) begin
          mod_d  = d_mod;
          pend_d = cand_desc;
          if (d_sib_next) begin
            state_d = ST_SIB;
          end else if (cand_desc.disp_len == '0) begin
            ev_finish = 1'b1;
            res_d     = cand_desc;
          end else begin
            cnt_load = 1'b1;
            cnt_val  = cand_desc.disp_len;
            state_d  = ST_DISP;
          end
        end
      end
      ST_SIB: begin
        if (ev_sib_take) begin
          pend_d = cand_sib;
          if (cand_sib.disp_len == '0) begin
            ev_finish = 1'b1;
            res_d     = cand_sib;
            state_d   = ST_DESC;
          end else begin
            cnt_load = 1'b1;
            cnt_val  = cand_sib.disp_len;
            state_d  = ST_DISP;
          end
        end
      end
      ST_DISP: begin
        if (ev_disp_take && cnt_last) begin
          ev_finish = 1'b1;
          res_d     = pend_q;
          state_d   = ST_DESC;
        end
      end
      default: state_d = ST_DESC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_DESC;
      mod_q   <= '0;
      pend_q  <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mod_q   <= mod_d;
      pend_q  <= pend_d;
      res_q   <= res_d;
      done_q  <= ev_finish;
    end
  end

  assign done_o      = done_q;
  assign is_reg_o    = res_q.is_reg;
  assign reg_field_o = res_q.reg_f;
  assign rm_reg_o    = res_q.rm_reg;
  assign base_vld_o  = res_q.base_vld;
  assign base_reg_o  = res_q.base;
  assign index_vld_o = res_q.idx_vld;
  assign index_reg_o = res_q.idx;
  assign scale_mul_o = res_q.scale_mul;
  assign disp_len_o  = res_q.disp_len;
  assign total_len_o = res_q.total_len;

endmodule

// File: rtl/a32_addr_checker.sv
module a32_addr_checker
  import a32_pkg::*;
#(
  parameter int SHORT_DISP = 1,
  parameter int LONG_DISP  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_valid_i,
  input logic             done_o,
  input logic             is_reg_o,
  input logic [2:0]       reg_field_o,
  input logic             base_vld_o,
  input logic [2:0]       base_reg_o,
  input logic             index_vld_o,
  input logic [2:0]       index_reg_o,
  input logic [3:0]       scale_mul_o,
  input logic [LEN_W-1:0] disp_len_o,
  input logic [LEN_W-1:0] total_len_o,
  input logic             ev_desc_take,
  input logic             ev_sib_take,
  input logic             ev_disp_take,
  input logic             ev_finish
);

  localparam logic [LEN_W-1:0] SL = LEN_W'(SHORT_DISP);
  localparam logic [LEN_W-1:0] LL = LEN_W'(LONG_DISP);

  // R2
  a_r2_direct_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && is_reg_o) |-> (total_len_o == LEN_W'(1) && disp_len_o == '0
                              && !base_vld_o && !index_vld_o && scale_mul_o == 4'd1));

  // R3 and R7: an absent base on a memory operand always brings the long displacement
  a_r3_no_base_long: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !is_reg_o && !base_vld_o) |-> (disp_len_o == LL && base_reg_o == 3'd0));

  // R5
  a_r5_scale_power: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones(scale_mul_o) == 1));

  // R6
  a_r6_index_zero_when_absent: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !index_vld_o) |-> (index_reg_o == 3'd0));

  // R9
  a_r9_disp_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (disp_len_o == '0 || disp_len_o == SL || disp_len_o == LL));

  // R10: total length is the descriptor, an optional extra byte, and the displacement
  a_r10_total_sum: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((total_len_o - disp_len_o == LEN_W'(1))
             || (total_len_o - disp_len_o == LEN_W'(2) && !is_reg_o)));

  // R4: an index can only come from the extra byte
  a_r4_index_needs_sib: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && index_vld_o) |-> (total_len_o - disp_len_o == LEN_W'(2)));

  // R10
  a_r10_strobe_follows_finish: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> done_o);

  // R10
  a_r10_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_finish |=> !done_o);

  // R10
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(total_len_o) && $stable(disp_len_o) && $stable(reg_field_o)
                 && $stable(base_reg_o) && $stable(index_reg_o) && $stable(scale_mul_o)));

  // R11
  a_r11_idle_consumes_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid_i |-> !(ev_desc_take || ev_sib_take || ev_disp_take || ev_finish));

  // R11: at most one stage consumes a byte
  a_r11_single_consumer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_desc_take, ev_sib_take, ev_disp_take}));

endmodule

bind a32_addr_decoder a32_addr_checker #(
  .SHORT_DISP (SHORT_DISP),
  .LONG_DISP  (LONG_DISP)
) u_chk (.*);

// File: tb/tb_a32_addr_decoder.sv
module tb_a32_addr_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_valid_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       done_o, is_reg_o, base_vld_o, index_vld_o;
  logic [2:0] reg_field_o, rm_reg_o, base_reg_o, index_reg_o;
  logic [3:0] scale_mul_o, disp_len_o, total_len_o;

  always #10 clk = ~clk;  // 50 MHz

  a32_addr_decoder dut (
    .clk, .rst_n, .byte_valid_i, .byte_i, .done_o, .is_reg_o, .reg_field_o,
    .rm_reg_o, .base_vld_o, .base_reg_o, .index_vld_o, .index_reg_o,
    .scale_mul_o, .disp_len_o, .total_len_o
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;
  int lcg = 12345;

  // Reference model state
  logic [7:0] cur[$];
  int e_done = 0, e_isreg = 0, e_reg = 0, e_rm = 0, e_bv = 0, e_b = 0;
  int e_iv = 0, e_i = 0, e_sc = 0, e_dl = 0, e_tl = 0;
  string e_tag = "R12";
  bit prev_idle = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    chk(prev_idle ? "R11" : "R10", "done strobe", int'(done_o), e_done);
    chk("R1", "reg field", int'(reg_field_o), e_reg);
    chk(e_tag, "is_reg", int'(is_reg_o), e_isreg);
    chk(e_tag, "rm reg", int'(rm_reg_o), e_rm);
    chk(e_tag, "base valid", int'(base_vld_o), e_bv);
    chk(e_tag, "base reg", int'(base_reg_o), e_b);
    chk(e_tag, "index valid", int'(index_vld_o), e_iv);
    chk(e_tag, "index reg", int'(index_reg_o), e_i);
    chk(e_tag, "scale mult", int'(scale_mul_o), e_sc);
    chk(e_tag, "disp len", int'(disp_len_o), e_dl);
    chk("R10", "total len", int'(total_len_o), e_tl);
  endtask

  function automatic int dlen(input int md, input bit esc);
    if (md == 1) return 1;
    if (md == 2) return 4;
    return esc ? 4 : 0;
  endfunction

  // Behavioural model: decides the expected outputs after the next edge
  task automatic model_take(input logic [7:0] b);
    int md, rm, need, n, ss, ix, bs;
    cur.push_back(b);
    n  = cur.size();
    md = int'(cur[0][7:6]);
    rm = int'(cur[0][2:0]);
    if (md == 3) need = 1;
    else if (rm != 4) need = 1 + dlen(md, rm == 5);
    else if (n < 2) need = 99;
    else need = 2 + dlen(md, int'(cur[1][2:0]) == 5);
    if (n != need) begin
      e_done = 0;
      return;
    end
    e_done = 1;
    e_reg = int'(cur[0][5:3]);
    e_tl = need;
    if (md == 3) begin
      e_tag = "R2"; e_isreg = 1; e_rm = rm; e_bv = 0; e_b = 0;
      e_iv = 0; e_i = 0; e_sc = 1; e_dl = 0;
    end else if (rm != 4) begin
      e_isreg = 0; e_rm = 0; e_iv = 0; e_i = 0; e_sc = 1;
      e_dl = need - 1;
      if (md == 0 && rm == 5) begin e_tag = "R3"; e_bv = 0; e_b = 0; end
      else begin e_tag = "R9"; e_bv = 1; e_b = rm; end
    end else begin
      ss = int'(cur[1][7:6]); ix = int'(cur[1][5:3]); bs = int'(cur[1][2:0]);
      e_isreg = 0; e_rm = 0; e_dl = need - 2;
      e_sc = 1 << ss;
      e_iv = (ix != 4); e_i = (ix != 4) ? ix : 0;
      if (bs == 5 && md == 0) begin e_tag = "R7"; e_bv = 0; e_b = 0; end
      else begin e_bv = 1; e_b = bs; e_tag = (bs == 5) ? "R8" : "R5"; end
      if (ix == 4) e_tag = "R6";
      if (e_tag == "R5" && need == 2) e_tag = "R4";
    end
    cur.delete();
  endtask

  task automatic tick(input bit v, input logic [7:0] b);
    @(negedge clk);
    compare_all();
    prev_idle = !v;
    byte_valid_i = v;
    byte_i = b;
    if (v) model_take(b);
    else e_done = 0;
  endtask

  function automatic bit gap();
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    return ((lcg >> 16) & 3) == 0;
  endfunction

  // Feed one operand; the model tells when it is complete
  task automatic send(input logic [7:0] desc, input logic [7:0] sib, input bit stalls);
    int k = 0;
    do begin
      if (stalls && gap()) tick(0, 8'hA5);
      tick(1, (k == 0) ? desc : (k == 1) ? sib : 8'(8'h30 + k));
      k++;
    end while (e_done == 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R12: bytes presented during reset are ignored, outputs are zero
    byte_valid_i = 1'b1;
    byte_i = 8'hC3;
    repeat (3) @(negedge clk);
    chk("R12", "done in reset", int'(done_o), 0);
    chk("R12", "total in reset", int'(total_len_o), 0);
    chk("R12", "scale in reset", int'(scale_mul_o), 0);
    chk("R12", "base valid in reset", int'(base_vld_o), 0);
    byte_valid_i = 1'b0;
    rst_n = 1'b1;
    tick(0, 8'h00);
    tick(0, 8'h00);

    // Back-to-back register operands, no stalls (R2)
    for (int r = 0; r < 8; r++) send(8'(8'hC0 | (r << 3) | (7 - r)), 8'h00, 0);

    // All descriptor values, with stalls
    for (int m = 0; m < 256; m++) send(8'(m), 8'((m * 37 + 11) & 255), 1);

    // All scale-index-base values under each memory mod
    for (int md = 0; md < 3; md++)
      for (int s = 0; s < 256; s++)
        send(8'((md << 6) | ((s & 7) << 3) | 4), 8'(s), (s & 1) == 1);

    // Long idle run mid-operand (R11)
    tick(1, 8'h84);
    repeat (5) tick(0, 8'hFF);
    tick(1, 8'h25);
    repeat (3) tick(0, 8'hFF);
    for (int k = 0; k < 4; k++) tick(1, 8'h11);
    repeat (3) tick(0, 8'h00);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule